// File: doc/BRIEF.md
# Streaming Shortened Reed-Solomon Encoder

This block turns a stream of 8-bit message symbols into systematic Reed-Solomon codewords over GF(2^8). The field is reduced by x^8+x^4+x^3+x^2+1 (0x11D), and the primitive element is alpha = 2. The correcting power T and the first generator root exponent J0 are elaboration parameters. The generator polynomial g(x) is the product of (x + alpha^i) for i = J0 .. J0+2T-1. Its coefficients are computed by a constant function, so the parity logic is a fixed set of constant GF multipliers.

Each packet chooses its own codeword length N. N is read from a sideband input on the beat that carries the start-of-packet flag, so consecutive packets can be shortened by different amounts. The first N-2T symbols pass straight through to the output, combinationally and in the same cycle. During that time the parity shift register absorbs each symbol. The block then stops taking input and sends the 2T parity symbols, highest degree first, with a last flag on the final one.

Both streams use valid/ready. While message symbols pass through, input ready is the output ready: an input beat completes exactly when the matching output beat completes, and the block stores no data. While parity is sent, input ready is low, output valid is high, and the parity symbol holds steady until the consumer accepts it.

Top module: `rs_stream_encoder`

## Requirements
- R1: The parity symbols equal the remainder of m(x)*x^(2T) divided by g(x), with symbols in GF(2^8) under 0x11D and alpha = 2. Every complete output codeword therefore evaluates to zero at alpha^i for i = J0 .. J0+2T-1. The first symbol sent is the highest-degree coefficient.
- R2: The first N-2T output symbols equal the accepted input symbols, in order and unchanged. Each one is sent in the same cycle its input beat is accepted.
- R3: Exactly 2T parity symbols follow the message, highest degree first. out_last is high on the final parity symbol only.
- R4: N is sampled from in_len on the accepted beat that has in_sync high while the block is idle. A packet is N symbols long, and N may differ from one packet to the next.
- R5: If in_len is below 2T+1 or above N_MAX (255), N = N_MAX is used. In that case len_err is high from the cycle after the start beat until the next packet start; a valid length clears it at that point.
- R6: During the message, in_ready equals out_ready. During parity, in_ready is 0 and out_valid is 1, and out_data is held while out_ready is low.
- R7: While idle, beats with in_sync low are consumed (in_ready = 1) and discarded. out_valid stays 0, and those beats do not affect later codewords.
- R8: After reset, out_valid = 0 and len_err = 0, and in_ready = 1 while in_sync is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted when high with in_valid |
| in_data | input | 8 | Message symbol |
| in_sync | input | 1 | Marks the first symbol of a packet |
| in_len | input | LEN_W (9) | Codeword length N, sampled with in_sync |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Codeword symbol |
| out_last | output | 1 | Final parity symbol of the codeword |
| len_err | output | 1 | Last start beat had an out-of-range length |

## Verification
Random-valued messages are encoded at full length, at a mid shortening, and at the one-symbol minimum. Together these show whether the counter loads the message length correctly from each N and whether the last flag tracks it. An all-zero message must give all-zero parity, and random messages must give codewords with zero syndromes at every generator root. The syndrome test catches a wrong generator coefficient even where the bench's long-division reference would agree. A stalling consumer shows whether message beats stay locked to output beats and whether parity holds under back-pressure. Out-of-range lengths followed by a valid one separate clamping from rejection, and show that the error flag clears. Idle beats without sync, followed by a packet, show that stray input never reaches the shift register.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W     = 8;
  localparam int MAX_ROOTS = 64;

  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_MSG = 2'd1, PH_PAR = 2'd2} phase_t;

  // shift-and-reduce product; red holds the low bits of the field polynomial
  function automatic sym_t gf_mul(sym_t a, sym_t b, sym_t red);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ red) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic sym_t gf_pow(sym_t base, int e, sym_t red);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < e; i++) r = gf_mul(r, base, red);
    return r;
  endfunction

  // coefficient idx (of x^idx) of prod (x + base^(j0+k)), k = 0..two_t-1
  function automatic sym_t gen_coef(int two_t, int j0, sym_t base, sym_t red, int idx);
    sym_t c [0:MAX_ROOTS];
    sym_t root;
    for (int i = 0; i <= MAX_ROOTS; i++) c[i] = '0;
    c[0] = sym_t'(1);
    for (int k = 0; k < two_t; k++) begin
      root = gf_pow(base, j0 + k, red);
      for (int j = k + 1; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], root, red);
      c[0] = gf_mul(c[0], root, red);
    end
    return c[idx];
  endfunction
endpackage

// File: rtl/rs_gf_const_mult.sv
module rs_gf_const_mult
  import rs_enc_pkg::*;
#(
  parameter sym_t COEF = '0,
  parameter sym_t RED  = 8'h1D
) (
  input  sym_t a,
  output sym_t y
);
  assign y = gf_mul(a, COEF, RED);
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int          TWO_T = 16,
  parameter int          J0    = 0,
  parameter int unsigned POLY  = 32'h11D,
  parameter int unsigned ALPHA = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic absorb,
  input  logic shift,
  input  sym_t din,
  output sym_t par_top
);
  localparam sym_t RED  = POLY[SYM_W-1:0];
  localparam sym_t BASE = ALPHA[SYM_W-1:0];

  logic [TWO_T-1:0][SYM_W-1:0] stage_q;
  logic [TWO_T-1:0][SYM_W-1:0] prod;
  sym_t fb;

  assign fb      = din ^ stage_q[TWO_T-1];
  assign par_top = stage_q[TWO_T-1];

  for (genvar g = 0; g < TWO_T; g++) begin : g_tap
    localparam sym_t COEF = gen_coef(TWO_T, J0, BASE, RED, g);
    rs_gf_const_mult #(.COEF(COEF), .RED(RED)) u_mul (.a(fb), .y(prod[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (absorb) begin
      stage_q[0] <= prod[0];
      for (int i = 1; i < TWO_T; i++) stage_q[i] <= stage_q[i-1] ^ prod[i];
    end else if (shift) begin
      stage_q[0] <= '0;
      for (int i = 1; i < TWO_T; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // R6
  absorb_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(absorb && shift));
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int T     = 8,
  parameter int N_MAX = 255,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sync,
  input  logic [LEN_W-1:0] in_len,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             sel_par,
  output logic             absorb,
  output logic             shift,
  output logic             len_err
);
  localparam int TWO_T = 2 * T;
  localparam int CNT_W = $clog2(N_MAX + 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             len_bad;
  logic [CNT_W-1:0] k_first;

  always_comb begin
    len_bad = (int'(in_len) < TWO_T + 1) || (int'(in_len) > N_MAX);
    k_first = len_bad ? CNT_W'(N_MAX - TWO_T) : CNT_W'(int'(in_len) - TWO_T);
  end

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    sel_par   = 1'b0;
    absorb    = 1'b0;
    shift     = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        in_ready  = in_sync ? out_ready : 1'b1;
        out_valid = in_valid && in_sync;
        absorb    = in_valid && in_sync && out_ready;
      end
      PH_MSG: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        absorb    = in_valid && out_ready;
      end
      PH_PAR: begin
        out_valid = 1'b1;
        sel_par   = 1'b1;
        shift     = out_ready;
        out_last  = (cnt_q == CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (absorb) begin
          err_q <= len_bad;
          if (k_first == CNT_W'(1)) begin
            ph_q  <= PH_PAR;
            cnt_q <= CNT_W'(TWO_T);
          end else begin
            ph_q  <= PH_MSG;
            cnt_q <= k_first - CNT_W'(1);
          end
        end
        PH_MSG: if (absorb) begin
          if (cnt_q == CNT_W'(1)) begin
            ph_q  <= PH_PAR;
            cnt_q <= CNT_W'(TWO_T);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_PAR: if (shift) begin
          if (cnt_q == CNT_W'(1)) ph_q <= PH_IDLE;
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign len_err = err_q;

  // R4
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (cnt_q != '0));
  // R3
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (ph_q == PH_IDLE));
  // R6
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_par && !out_ready) |=> (sel_par && out_valid));
  // R5
  len_err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && absorb && len_bad) |=> err_q);
endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
  import rs_enc_pkg::*;
#(
  parameter int          T          = 8,
  parameter int          J0         = 0,
  parameter int          N_MAX      = 255,
  parameter int          LEN_W      = 9,
  parameter int unsigned FIELD_POLY = 32'h11D,
  parameter int unsigned ALPHA      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_sync,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last,
  output logic             len_err
);
  localparam int TWO_T = 2 * T;

  logic sel_par;
  logic absorb;
  logic shift;
  sym_t par_top;

  rs_enc_ctrl #(.T(T), .N_MAX(N_MAX), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_len(in_len), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .out_last(out_last), .sel_par(sel_par),
    .absorb(absorb), .shift(shift), .len_err(len_err)
  );

  rs_parity_lfsr #(.TWO_T(TWO_T), .J0(J0), .POLY(FIELD_POLY), .ALPHA(ALPHA)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .absorb(absorb), .shift(shift),
    .din(in_data), .par_top(par_top)
  );

  assign out_data = sel_par ? par_top : in_data;

  // R6
  par_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_par && out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/rs_stream_encoder_test.sv
module rs_stream_encoder_test;
  localparam int CLK_P = 10;
  localparam int T     = 8;
  localparam int TWO_T = 2 * T;
  localparam int J0    = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sync = 1'b0;
  logic [8:0] in_len = 9'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       len_err;

  rs_stream_encoder #(.T(T), .J0(J0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sync(in_sync), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .len_err(len_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] msg [0:254];
  logic [7:0] got [0:299];
  logic       got_last [0:299];
  logic [7:0] gb [0:TWO_T];
  int n_out, n_align_bad, n_hold_bad, n_par_rdy_bad;

  function automatic logic [7:0] xtime(logic [7:0] x);
    return x[7] ? ({x[6:0], 1'b0} ^ 8'h1D) : {x[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) p = xtime(p) ^ (a[i] ? b : 8'h00);
    return p;
  endfunction

  function automatic logic [7:0] bpow(int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = bmul(r, 8'h02);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_gen();
    logic [7:0] root;
    for (int i = 0; i <= TWO_T; i++) gb[i] = 8'h00;
    gb[0] = 8'h01;
    for (int k = 0; k < TWO_T; k++) begin
      root = bpow(J0 + k);
      for (int j = k + 1; j >= 1; j--) gb[j] = gb[j-1] ^ bmul(gb[j], root);
      gb[0] = bmul(gb[0], root);
    end
  endtask

  task automatic fill_msg(int k, int seed, bit zero);
    int v = seed;
    for (int i = 0; i < k; i++) begin
      v = (v * 29 + 71) % 256;
      msg[i] = zero ? 8'h00 : v[7:0];
    end
  endtask

  task automatic run_pkt(int n_in, int kmsg, int stall_mod);
    int sent = 0;
    int cyc = 0;
    bit done = 0;
    bit hold_pending = 0;
    logic [7:0] hold_val = 8'h00;
    bit in_hs, out_hs;
    n_out = 0; n_align_bad = 0; n_hold_bad = 0; n_par_rdy_bad = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      in_valid  = (sent < kmsg);
      in_data   = (sent < kmsg) ? msg[sent] : 8'h00;
      in_sync   = (sent == 0);
      in_len    = n_in[8:0];
      out_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      #(CLK_P/4);
      in_hs  = in_valid && in_ready;
      out_hs = out_valid && out_ready;
      if (hold_pending && !(out_valid && out_data == hold_val)) n_hold_bad++;
      hold_pending = 0;
      if (sent < kmsg) begin
        if (in_hs != out_hs) n_align_bad++;
      end else begin
        if (out_valid && in_ready) n_par_rdy_bad++;
        if (out_valid && !out_ready) begin
          hold_pending = 1;
          hold_val = out_data;
        end
      end
      if (in_hs) sent++;
      if (out_hs && n_out < 300) begin
        got[n_out] = out_data;
        got_last[n_out] = out_last;
        n_out++;
        if (out_last) done = 1;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sync = 1'b0; out_ready = 1'b1;
  endtask

  task automatic check_pkt(string req, int n_exp);
    int c [0:299];
    int kmsg = n_exp - TWO_T;
    int errs = 0;
    int lasts = 0;
    int syn_bad = 0;
    logic [7:0] s, x;
    for (int i = 0; i < n_exp; i++) c[i] = (i < kmsg) ? int'(msg[i]) : 0;
    for (int i = 0; i < kmsg; i++)
      if (c[i] != 0)
        for (int j = 1; j <= TWO_T; j++)
          c[i+j] = c[i+j] ^ int'(bmul(c[i][7:0], gb[TWO_T-j]));
    for (int i = 0; i < n_exp; i++) begin
      if (i < kmsg && i < n_out && got[i] != msg[i]) errs++;
      if (i >= kmsg && i < n_out && int'(got[i]) != c[i]) errs++;
    end
    check(n_out == n_exp, req, "codeword length", n_out, n_exp);
    check(errs == 0, req, "symbol mismatches", errs, 0);
    for (int i = 0; i < n_out; i++) if (got_last[i]) lasts++;
    check(lasts == 1 && n_out > 0 && got_last[n_out-1], req, "last flag count (R3)", lasts, 1);
    for (int r = 0; r < TWO_T; r++) begin
      x = bpow(J0 + r);
      s = 8'h00;
      for (int i = 0; i < n_out; i++) s = bmul(s, x) ^ got[i];
      if (s != 8'h00) syn_bad++;
    end
    check(syn_bad == 0, req, "nonzero syndromes (R1)", syn_bad, 0);
    check(n_align_bad == 0, req, "message beat misalignment (R2)", n_align_bad, 0);
    check(n_par_rdy_bad == 0, req, "in_ready during parity (R6)", n_par_rdy_bad, 0);
    check(n_hold_bad == 0, req, "parity not held under stall (R6)", n_hold_bad, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    #(CLK_P/4);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    check(len_err == 1'b0, "R8", "len_err after reset", int'(len_err), 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic test_full();
    fill_msg(239, 7, 0);
    run_pkt(255, 239, 0);
    check_pkt("R1 R2 R4 full", 255);
  endtask

  task automatic test_short();
    fill_msg(24, 3, 0);
    run_pkt(40, 24, 0);
    check_pkt("R4 shortened", 40);
    fill_msg(1, 11, 0);
    run_pkt(17, 1, 0);
    check_pkt("R4 minimum", 17);
  endtask

  task automatic test_zero();
    fill_msg(50, 0, 1);
    run_pkt(66, 50, 0);
    check_pkt("R1 zero message", 66);
  endtask

  task automatic test_clamp();
    fill_msg(239, 5, 0);
    run_pkt(5, 239, 0);
    check_pkt("R5 low length", 255);
    check(len_err == 1'b1, "R5", "len_err after short N", int'(len_err), 1);
    fill_msg(239, 21, 0);
    run_pkt(300, 239, 0);
    check_pkt("R5 high length", 255);
    check(len_err == 1'b1, "R5", "len_err after large N", int'(len_err), 1);
    fill_msg(4, 17, 0);
    run_pkt(20, 4, 0);
    check_pkt("R5 valid after error", 20);
    check(len_err == 1'b0, "R5", "len_err after valid N", int'(len_err), 0);
  endtask

  task automatic test_backpressure();
    fill_msg(30, 9, 0);
    run_pkt(46, 30, 3);
    check_pkt("R6 stalled consumer", 46);
  endtask

  task automatic test_idle_drop();
    int bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sync = 1'b0; in_data = 8'hFF; in_len = 9'd30;
      #(CLK_P/4);
      if (out_valid !== 1'b0 || in_ready !== 1'b1) bad++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(bad == 0, "R7", "idle beats without sync", bad, 0);
    fill_msg(10, 13, 0);
    run_pkt(26, 10, 0);
    check_pkt("R7 after dropped beats", 26);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    build_gen();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_full();
    test_short();
    test_zero();
    test_clamp();
    test_backpressure();
    test_idle_drop();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule